// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the bus STOP condition for a single-master I2C controller once a byte transfer has ended. At that point the rest of the controller holds SCL low after the ninth clock. Software then sets the stop-enable bit with a one-cycle request pulse. The sequencer pulls SDA low, releases SCL, and then releases SDA so that SDA rises while SCL is high. A reloadable baud-rate down-counter times each step. Every step that depends on a pin level starts only after the block has sampled that pin at the expected level.

Both lines are open-drain. The block only asserts output enables that pull a line low, and it reads the real pin levels back through one sampling register. A bus monitor watches the sampled lines for START and STOP conditions and keeps a status bit for each. One baud period after the STOP is seen, the block clears the enable bit itself and raises a sticky interrupt flag. A transmit-buffer write that arrives while the enable bit is set is refused and raises a sticky collision flag.

Top module: `i2c_stop_sequencer`

## Requirements
- R1: A request pulse on `stop_req` is accepted only when `bus_held` is 1 and `stop_en` is 0. On the next clock `stop_en`, `sda_oe` and `scl_oe` are all 1. In every other case the request is ignored and the outputs do not change.
- R2: A baud period lasts `brg_reload`+1 clocks. SCL is released (`scl_oe` falls) exactly `brg_reload`+3 clocks after an accepted request. The extra two clocks are the pin sampling register and the wait decision that follows it.
- R3: SDA is released (`sda_oe` falls) exactly `brg_reload`+3 clocks after the SCL pin first reads high once it has been released.
- R4: The monitor sets `stop_seen` and clears `start_seen` two clocks after SDA rises while SCL is high. It sets `start_seen` and clears `stop_seen` two clocks after SDA falls while SCL is high. SDA edges while SCL is low change neither bit.
- R5: Exactly `brg_reload`+1 clocks after `stop_seen` rises at the end of a sequence, `stop_en` returns to 0 and `irq_flag` becomes 1.
- R6: If a slave holds SCL low after the block releases it, the baud counter stays at the reload value and SDA stays driven low. The timing of R3 begins only when SCL reads high.
- R7: A `buf_wr` while `stop_en` is 1 sets `wcol` and leaves `buf_data` unchanged. A `buf_wr` while `stop_en` is 0 loads `buf_wdata` into `buf_data` and leaves `wcol` alone.
- R8: `irq_flag` and `wcol` stay set until `clr_irq` or `clr_wcol`, respectively, is pulsed.
- R9: While `stop_en` is 0, both `sda_oe` and `scl_oe` are 0. The block never drives a line high.
- R10: After reset, `stop_en`, `sda_oe`, `scl_oe`, `irq_flag`, `wcol`, `stop_seen` and `start_seen` are 0, and `buf_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle pulse that sets the stop-enable bit |
| bus_held | input | 1 | The controller is idle at the end of a transfer with SCL held low |
| brg_reload | input | BRG_W | Baud counter reload value; one period is this value plus one clocks |
| sda_in | input | 1 | SDA pin level |
| scl_in | input | 1 | SCL pin level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| clr_wcol | input | 1 | Clears the collision flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| stop_en | output | 1 | Stop-enable bit; cleared by hardware when the sequence finishes |
| start_seen | output | 1 | A START was the last bus condition seen |
| stop_seen | output | 1 | A STOP was the last bus condition seen |
| irq_flag | output | 1 | Sticky interrupt flag set when a sequence completes |
| wcol | output | 1 | Sticky write-collision flag |
| buf_data | output | DATA_W | Transmit buffer contents |

## Verification
The bench builds the block with BRG_W = 5 and DATA_W = 8. The 5-bit counter lets one run use the full-scale reload of 31 and another use a reload of 0, the single-clock period, within a few hundred cycles. A reload of 3 covers the ordinary case and is also used for the run in which a slave stretches SCL. The small counter means the largest reload still checks the counter's terminal-count boundary without long waits.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_DRIVE,
    ST_SETUP,
    ST_SCL_REL,
    ST_SCL_HIGH,
    ST_SDA_REL,
    ST_TAIL
  } stop_state_e;

  // states that wait for a sampled pin level; the baud counter is held at reload
  function automatic logic is_pin_wait(stop_state_e s);
    return (s == ST_SDA_DRIVE) || (s == ST_SCL_REL) || (s == ST_SDA_REL);
  endfunction

  // states that last exactly one baud period
  function automatic logic is_timed(stop_state_e s);
    return (s == ST_SETUP) || (s == ST_SCL_HIGH) || (s == ST_TAIL);
  endfunction

  function automatic logic pulls_sda(stop_state_e s);
    return (s == ST_SDA_DRIVE) || (s == ST_SETUP) ||
           (s == ST_SCL_REL)   || (s == ST_SCL_HIGH);
  endfunction

  function automatic logic pulls_scl(stop_state_e s);
    return (s == ST_SDA_DRIVE) || (s == ST_SETUP);
  endfunction

endpackage

// File: rtl/i2c_stop_brg.sv
module i2c_stop_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] reload,
  input  logic             load,
  input  logic             run,
  output logic [BRG_W-1:0] cnt,
  output logic             expire
);

  localparam logic [BRG_W-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= ZERO;
    else if (load)
      cnt <= reload;
    else if (run && (cnt != ZERO))
      cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == ZERO);

endmodule

// File: rtl/i2c_stop_bus_mon.sv
module i2c_stop_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_s,
  output logic scl_s,
  output logic stop_evt,
  output logic start_evt,
  output logic stop_seen,
  output logic start_seen
);

  logic sda_d;

  // single sampling stage; idle bus reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s <= 1'b1;
      scl_s <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      sda_s <= sda_in;
      scl_s <= scl_in;
      sda_d <= sda_s;
    end
  end

  assign stop_evt  = scl_s &&  sda_s && !sda_d;
  assign start_evt = scl_s && !sda_s &&  sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_seen  <= 1'b0;
      start_seen <= 1'b0;
    end else if (stop_evt) begin
      stop_seen  <= 1'b1;
      start_seen <= 1'b0;
    end else if (start_evt) begin
      stop_seen  <= 1'b0;
      start_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
  import i2c_stop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_req,
  input  logic        bus_held,
  input  logic        sda_s,
  input  logic        scl_s,
  input  logic        stop_evt,
  input  logic        expire,
  output stop_state_e state,
  output logic        stop_en,
  output logic        sda_oe,
  output logic        scl_oe,
  output logic        brg_load,
  output logic        brg_run,
  output logic        seq_done
);

  stop_state_e nxt;
  logic        accept;

  assign accept   = (state == ST_IDLE) && !stop_en && stop_req && bus_held;
  assign seq_done = (state == ST_TAIL) && expire;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (accept)   nxt = ST_SDA_DRIVE;
      ST_SDA_DRIVE: if (!sda_s)   nxt = ST_SETUP;
      ST_SETUP:     if (expire)   nxt = ST_SCL_REL;
      ST_SCL_REL:   if (scl_s)    nxt = ST_SCL_HIGH;
      ST_SCL_HIGH:  if (expire)   nxt = ST_SDA_REL;
      ST_SDA_REL:   if (stop_evt) nxt = ST_TAIL;
      ST_TAIL:      if (expire)   nxt = ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stop_en <= 1'b0;
    end else begin
      state <= nxt;
      if (accept)
        stop_en <= 1'b1;
      else if (seq_done)
        stop_en <= 1'b0;
    end
  end

  assign brg_load = is_pin_wait(state);
  assign brg_run  = is_timed(state);
  assign sda_oe   = pulls_sda(state);
  assign scl_oe   = pulls_scl(state);

endmodule

// File: rtl/i2c_stop_sequencer.sv
module i2c_stop_sequencer
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              bus_held,
  input  logic [BRG_W-1:0]  brg_reload,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_oe,
  output logic              scl_oe,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              clr_wcol,
  input  logic              clr_irq,
  output logic              stop_en,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              irq_flag,
  output logic              wcol,
  output logic [DATA_W-1:0] buf_data
);

  logic             sda_s, scl_s, stop_evt, start_evt;
  logic             brg_load, brg_run, expire, seq_done;
  logic [BRG_W-1:0] brg_cnt;
  stop_state_e      state;
  logic             scl_wait;

  i2c_stop_bus_mon u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_in     (sda_in),
    .scl_in     (scl_in),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .stop_evt   (stop_evt),
    .start_evt  (start_evt),
    .stop_seen  (stop_seen),
    .start_seen (start_seen)
  );

  i2c_stop_brg #(.BRG_W(BRG_W)) u_brg (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (brg_reload),
    .load   (brg_load),
    .run    (brg_run),
    .cnt    (brg_cnt),
    .expire (expire)
  );

  i2c_stop_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .bus_held (bus_held),
    .sda_s    (sda_s),
    .scl_s    (scl_s),
    .stop_evt (stop_evt),
    .expire   (expire),
    .state    (state),
    .stop_en  (stop_en),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .brg_load (brg_load),
    .brg_run  (brg_run),
    .seq_done (seq_done)
  );

  // named event for the checker: waiting for released SCL to read high
  assign scl_wait = (state == ST_SCL_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      wcol     <= 1'b0;
      buf_data <= '0;
    end else begin
      if (seq_done)
        irq_flag <= 1'b1;
      else if (clr_irq)
        irq_flag <= 1'b0;

      if (buf_wr && stop_en)
        wcol <= 1'b1;
      else if (clr_wcol)
        wcol <= 1'b0;

      if (buf_wr && !stop_en)
        buf_data <= buf_wdata;
    end
  end

endmodule

// File: rtl/i2c_stop_checker.sv
module i2c_stop_checker #(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              bus_held,
  input logic              sda_oe,
  input logic              scl_oe,
  input logic              stop_en,
  input logic              stop_seen,
  input logic              start_seen,
  input logic              irq_flag,
  input logic              clr_irq,
  input logic              wcol,
  input logic              clr_wcol,
  input logic              buf_wr,
  input logic [DATA_W-1:0] buf_data,
  input logic [BRG_W-1:0]  brg_reload,
  input logic [BRG_W-1:0]  brg_cnt,
  input logic              scl_wait,
  input logic              scl_s
);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_en && stop_req && bus_held) |=> (stop_en && sda_oe && scl_oe));

  p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_en && stop_req && !bus_held) |=> !stop_en);

  p_sda_before_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> sda_oe);

  p_stop_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> (!sda_oe && !scl_oe && !start_seen));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_en) |-> (irq_flag && stop_seen));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_wait && !scl_s) |=> (brg_cnt == $past(brg_reload) && sda_oe));

  p_wcol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && stop_en) |=> (wcol && $stable(buf_data)));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_irq) |=> irq_flag);

  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !clr_wcol) |=> wcol);

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |-> (!sda_oe && !scl_oe));

endmodule

bind i2c_stop_sequencer i2c_stop_checker #(.BRG_W(BRG_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .bus_held   (bus_held),
  .sda_oe     (sda_oe),
  .scl_oe     (scl_oe),
  .stop_en    (stop_en),
  .stop_seen  (stop_seen),
  .start_seen (start_seen),
  .irq_flag   (irq_flag),
  .clr_irq    (clr_irq),
  .wcol       (wcol),
  .clr_wcol   (clr_wcol),
  .buf_wr     (buf_wr),
  .buf_data   (buf_data),
  .brg_reload (brg_reload),
  .brg_cnt    (brg_cnt),
  .scl_wait   (scl_wait),
  .scl_s      (scl_s)
);

// File: tb/test_i2c_stop_sequencer.sv
module test_i2c_stop_sequencer;

  localparam int BRG_W  = 5;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stop_req = 1'b0;
  logic              bus_held = 1'b0;
  logic [BRG_W-1:0]  brg_reload = '0;
  logic              sda_in, scl_in;
  logic              sda_oe, scl_oe;
  logic              buf_wr = 1'b0;
  logic [DATA_W-1:0] buf_wdata = '0;
  logic              clr_wcol = 1'b0;
  logic              clr_irq = 1'b0;
  logic              stop_en, start_seen, stop_seen, irq_flag, wcol;
  logic [DATA_W-1:0] buf_data;

  logic ext_sda_low = 1'b0;
  logic ext_scl_low = 1'b0;

  // open-drain wire model with pull-ups
  assign sda_in = !(sda_oe || ext_sda_low);
  assign scl_in = !(scl_oe || ext_scl_low);

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_stop_sequencer #(.BRG_W(BRG_W), .DATA_W(DATA_W)) i_i2c_stop_sequencer (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .bus_held(bus_held),
    .brg_reload(brg_reload), .sda_in(sda_in), .scl_in(scl_in),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .clr_wcol(clr_wcol), .clr_irq(clr_irq), .stop_en(stop_en),
    .start_seen(start_seen), .stop_seen(stop_seen), .irq_flag(irq_flag),
    .wcol(wcol), .buf_data(buf_data)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // which: 0 sda_oe, 1 scl_oe, 2 stop_seen, 3 stop_en
  task automatic wait_for(input int which, input logic v, output int t);
    int guard = 0;
    logic cur;
    forever begin
      case (which)
        0: cur = sda_oe;
        1: cur = scl_oe;
        2: cur = stop_seen;
        default: cur = stop_en;
      endcase
      if (cur == v || guard > 400) break;
      @(negedge clk);
      guard++;
    end
    t = (guard > 400) ? -1000 : cyc;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check_eq("R10", "stop_en", stop_en, 0);
    check_eq("R10", "sda_oe", sda_oe, 0);
    check_eq("R10", "scl_oe", scl_oe, 0);
    check_eq("R10", "irq_flag", irq_flag, 0);
    check_eq("R10", "wcol", wcol, 0);
    check_eq("R10", "stop_seen", stop_seen, 0);
    check_eq("R10", "start_seen", start_seen, 0);
    check_eq("R10", "buf_data", buf_data, 0);
  endtask

  task automatic idle_write();
    buf_wdata = 8'h3C;
    buf_wr = 1'b1;
    tick(1);
    buf_wr = 1'b0;
    check_eq("R7", "idle write stored", buf_data, 8'h3C);
    check_eq("R7", "idle write no wcol", wcol, 0);
  endtask

  task automatic ignored_request();
    bus_held = 1'b0;
    stop_req = 1'b1;
    tick(1);
    stop_req = 1'b0;
    tick(2);
    check_eq("R1", "ignored stop_en", stop_en, 0);
    check_eq("R1", "ignored sda_oe", sda_oe, 0);
    check_eq("R9", "ignored scl_oe", scl_oe, 0);
  endtask

  // START on the pins, then the transfer parks SCL low and frees SDA
  task automatic do_start();
    ext_sda_low = 1'b1;
    tick(3);
    check_eq("R4", "start_seen after START", start_seen, 1);
    check_eq("R4", "stop_seen after START", stop_seen, 0);
    ext_scl_low = 1'b1;
    tick(3);
    ext_sda_low = 1'b0;
    tick(3);
    check_eq("R4", "SDA rise with SCL low keeps start_seen", start_seen, 1);
    check_eq("R4", "SDA rise with SCL low no stop", stop_seen, 0);
  endtask

  task automatic run_stop(input int rl, input int hold, input bit collide);
    int t0, t1, trel, t2, t3, t4;
    int sda_bad;
    logic [DATA_W-1:0] prev_buf;
    brg_reload = rl[BRG_W-1:0];
    bus_held = 1'b1;
    tick(1);
    stop_req = 1'b1;
    tick(1);
    stop_req = 1'b0;
    bus_held = 1'b0;
    t0 = cyc;
    check_eq("R1", "accept stop_en", stop_en, 1);
    check_eq("R1", "accept sda_oe", sda_oe, 1);
    check_eq("R1", "accept scl_oe", scl_oe, 1);
    if (hold == 0) ext_scl_low = 1'b0;
    if (collide) begin
      prev_buf = buf_data;
      buf_wdata = 8'hA5;
      buf_wr = 1'b1;
      tick(1);
      buf_wr = 1'b0;
      check_eq("R7", "collision wcol", wcol, 1);
      check_eq("R7", "collision buffer unchanged", buf_data, prev_buf);
    end
    wait_for(1, 1'b0, t1);
    check_eq("R2", $sformatf("SCL release delay rl=%0d", rl), t1 - t0, rl + 3);
    if (hold > 0) begin
      sda_bad = 0;
      for (int i = 0; i < hold; i++) begin
        if (!sda_oe) sda_bad++;
        tick(1);
      end
      check_eq("R6", "SDA held low while SCL stretched", sda_bad, 0);
      ext_scl_low = 1'b0;
      trel = cyc;
    end else begin
      trel = t1;
    end
    wait_for(0, 1'b0, t2);
    check_eq(hold > 0 ? "R6" : "R3", $sformatf("SDA release delay rl=%0d", rl), t2 - trel, rl + 3);
    wait_for(2, 1'b1, t3);
    check_eq("R4", "stop_seen delay", t3 - t2, 2);
    check_eq("R4", "start_seen cleared by STOP", start_seen, 0);
    wait_for(3, 1'b0, t4);
    check_eq("R5", $sformatf("enable clear delay rl=%0d", rl), t4 - t3, rl + 1);
    check_eq("R5", "irq_flag set", irq_flag, 1);
    tick(2);
    check_eq("R9", "idle SDA released", sda_oe, 0);
    check_eq("R9", "idle SCL released", scl_oe, 0);
    check_eq("R8", "irq_flag sticky", irq_flag, 1);
  endtask

  task automatic clear_flags(input bit expect_wcol);
    check_eq("R8", "wcol before clear", wcol, expect_wcol ? 1 : 0);
    clr_irq = 1'b1;
    clr_wcol = 1'b1;
    tick(1);
    clr_irq = 1'b0;
    clr_wcol = 1'b0;
    check_eq("R8", "irq_flag cleared", irq_flag, 0);
    check_eq("R8", "wcol cleared", wcol, 0);
  endtask

  initial begin
    tick(200000 - 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    idle_write();
    ignored_request();
    do_start();
    run_stop(3, 0, 1'b0);
    clear_flags(1'b0);
    do_start();
    run_stop(0, 0, 1'b1);
    clear_flags(1'b1);
    do_start();
    run_stop(31, 0, 1'b0);
    clear_flags(1'b0);
    do_start();
    run_stop(3, 7, 1'b0);
    clear_flags(1'b0);
    tick(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule